// File: doc/BRIEF.md
# Triangle Scanline Span Rasterizer

This block turns one screen-space triangle into the set of pixels it covers. The three vertices come in together in signed fixed point. The block orders them from top to bottom and works out a horizontal-step-per-row value for each of the three edges. It then moves each edge onto the first pixel-centre row and walks down the screen, adding the step value once per row.

On each row the two active edges give a pair of x bounds. Every integer pixel between those bounds goes out, one per cycle, on a valid/ready stream together with its row number. A flag marks the final pixel of the triangle. A single sequential divider computes the edge slopes one after another. While a triangle is in progress the block refuses new input.

Top module: `tri_raster`

## Requirements
- R1: The vertices are sorted by y, smallest first. The emitted pixel stream does not depend on the order in which the three vertices are presented.
- R2: Coordinates are signed 16-bit with 4 fraction bits. The slope of an edge is held in 32-bit two's complement with 16 fraction bits. Its value is sign(dx) × floor(|dx|·65536 / dy), where dx and dy are taken from the upper endpoint to the lower one. An edge with dy = 0 is never divided; its slope is zero.
- R3: An edge that starts at (xa, ya) begins at xa·4096 + floor(slope·f / 16), in 16-fraction-bit units, where f = (16 − (ya mod 16)) mod 16.
- R4: The top-to-bottom edge advances by its slope on every row. The other side uses the top-to-middle edge for rows below ceil(ym). From row ceil(ym) it restarts at the snapped start of the middle-to-bottom edge and advances by that edge's slope.
- R5: Rows run over ceil(yt) ≤ row < ceil(yb). On a row with edge positions a and b, pixel x is covered when ceil(min(a,b)) ≤ x < ceil(max(a,b)), with ceil taken to whole pixels.
- R6: Pixels are emitted row by row from top to bottom, with x increasing within a row.
- R7: pix_last is high on exactly the final pixel of a triangle. A triangle that covers no pixel emits nothing.
- R8: tri_ready is high exactly when busy is low. A triangle is taken when tri_valid and tri_ready are both high at a clock edge. busy then stays high until the final pixel has been handshaken, and falls within two cycles after that.
- R9: While pix_valid is high and pix_ready is low, pix_valid, pix_x, pix_y and pix_last hold their values.
- R10: After reset, pix_valid and busy are low and tri_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tri_valid | input | 1 | Triangle offered |
| tri_ready | output | 1 | Triangle can be taken |
| v0_x | input | 16 | Vertex 0 x, signed, 4 fraction bits |
| v0_y | input | 16 | Vertex 0 y, signed, 4 fraction bits |
| v1_x | input | 16 | Vertex 1 x |
| v1_y | input | 16 | Vertex 1 y |
| v2_x | input | 16 | Vertex 2 x |
| v2_y | input | 16 | Vertex 2 y |
| pix_valid | output | 1 | Pixel output valid |
| pix_ready | input | 1 | Downstream accepts pixel |
| pix_x | output | 13 | Pixel column, signed integer |
| pix_y | output | 13 | Pixel row, signed integer |
| pix_last | output | 1 | Final pixel of the triangle |
| busy | output | 1 | Triangle in progress |

## Verification
The assertions assume that vertex inputs stay within a range where the 16.16 edge positions and the 13-bit pixel numbers never wrap. They also assume that the slope quotient fits into 32 bits. The stimulus keeps every coordinate within a few tens of pixels of the origin, with both signs present, so steep edges still produce quotients far below that limit. The bench holds tri_valid for a single cycle and only while the block is idle. pix_ready patterns vary from always ready to mostly stalled, so the hold rule is exercised on many pixels.

// File: rtl/tri_raster_pkg.sv
package tri_raster_pkg;
  localparam int CW = 16;          // coordinate width
  localparam int FB = 4;           // coordinate fraction bits
  localparam int SF = 16;          // slope / edge fraction bits
  localparam int SW = 32;          // slope / edge width
  localparam int XW = CW - FB + 1; // integer pixel width
  localparam int NW = CW + 1 + SF; // divider numerator width

  typedef struct packed {
    logic signed [CW-1:0] x;
    logic signed [CW-1:0] y;
  } vtx_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIV, ST_SETUP, ST_ROW, ST_PIX, ST_DONE
  } walk_state_t;

  function automatic logic signed [XW-1:0] ceil_q4(input logic signed [CW-1:0] y);
    logic signed [CW:0] t;
    t = {y[CW-1], y} + (CW+1)'((1 << FB) - 1);
    return XW'(t >>> FB);
  endfunction

  function automatic logic signed [XW-1:0] ceil_q16(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] t;
    t = v + SW'((1 << SF) - 1);
    return XW'(t >>> SF);
  endfunction

  function automatic logic signed [SW-1:0] snap_x(input logic signed [CW-1:0] x,
                                                  input logic signed [CW-1:0] y,
                                                  input logic signed [SW-1:0] s);
    logic [FB:0]               f;
    logic signed [SW+FB+1:0]   prod;
    logic signed [SW-1:0]      base;
    f    = (y[FB-1:0] == '0) ? '0 : ((FB+1)'(1 << FB) - (FB+1)'(y[FB-1:0]));
    prod = s * $signed({1'b0, f});
    base = {{(SW-CW){x[CW-1]}}, x};
    base = base <<< (SF - FB);
    return base + SW'(prod >>> FB);
  endfunction
endpackage

// File: rtl/tri_cswap.sv
module tri_cswap
  import tri_raster_pkg::*;
(
  input  vtx_t a,
  input  vtx_t b,
  output vtx_t lo,
  output vtx_t hi
);
  logic swap;
  assign swap = b.y < a.y;
  assign lo   = swap ? b : a;
  assign hi   = swap ? a : b;
endmodule

// File: rtl/tri_vsort.sv
module tri_vsort
  import tri_raster_pkg::*;
(
  input  vtx_t in0,
  input  vtx_t in1,
  input  vtx_t in2,
  output vtx_t top,
  output vtx_t mid,
  output vtx_t bot
);
  vtx_t p0, p1, q1;

  tri_cswap u_s0 (.a(in0), .b(in1), .lo(p0),  .hi(p1));
  tri_cswap u_s1 (.a(p1),  .b(in2), .lo(q1),  .hi(bot));
  tri_cswap u_s2 (.a(p0),  .b(q1),  .lo(top), .hi(mid));
endmodule

// File: rtl/tri_slope_div.sv
module tri_slope_div #(
  parameter int NW = 33,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int CNTW = $clog2(NW + 1);

  logic [DW-1:0]   rem, den_r;
  logic [NW-1:0]   q;
  logic [CNTW-1:0] cnt;
  logic [DW:0]     sh, diff;
  logic            ge;

  assign sh   = {rem, q[NW-1]};
  assign ge   = sh >= {1'b0, den_r};
  assign diff = sh - {1'b0, den_r};
  assign busy = cnt != '0;
  assign quo  = q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      done  <= 1'b0;
      rem   <= '0;
      q     <= '0;
      den_r <= '0;
    end else begin
      done <= 1'b0;
      if (start && cnt == '0) begin
        rem   <= '0;
        q     <= num;
        den_r <= den;
        cnt   <= CNTW'(NW);
      end else if (cnt != '0) begin
        rem <= ge ? diff[DW-1:0] : sh[DW-1:0];
        q   <= {q[NW-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CNTW'(1)) done <= 1'b1;
      end
    end
  end

  // R2: partial remainder stays below the divisor during a division
  p_rem_below_den_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rem < den_r));
endmodule

// File: rtl/tri_pix_out.sv
module tri_pix_out #(
  parameter int XW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gen_valid,
  input  logic [XW-1:0] gen_x,
  input  logic [XW-1:0] gen_y,
  input  logic          flush,
  output logic          gen_take,
  output logic          empty,
  input  logic          pix_ready,
  output logic          pix_valid,
  output logic [XW-1:0] pix_x,
  output logic [XW-1:0] pix_y,
  output logic          pix_last
);
  logic          h_valid;
  logic [XW-1:0] h_x, h_y;
  logic          out_free;

  assign out_free = !pix_valid || pix_ready;
  assign gen_take = h_valid ? out_free : 1'b1;
  assign empty    = !h_valid && !pix_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_valid   <= 1'b0;
      h_x       <= '0;
      h_y       <= '0;
      pix_valid <= 1'b0;
      pix_x     <= '0;
      pix_y     <= '0;
      pix_last  <= 1'b0;
    end else begin
      if (pix_valid && pix_ready) pix_valid <= 1'b0;
      if (gen_valid && gen_take) begin
        if (h_valid) begin
          pix_valid <= 1'b1;
          pix_x     <= h_x;
          pix_y     <= h_y;
          pix_last  <= 1'b0;
        end
        h_valid <= 1'b1;
        h_x     <= gen_x;
        h_y     <= gen_y;
      end else if (flush && h_valid && out_free) begin
        pix_valid <= 1'b1;
        pix_x     <= h_x;
        pix_y     <= h_y;
        pix_last  <= 1'b1;
        h_valid   <= 1'b0;
      end
    end
  end

  // R9: a stalled pixel holds still
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_ready) |=>
      (pix_valid && $stable(pix_x) && $stable(pix_y) && $stable(pix_last)));

  // R7: nothing follows the final pixel
  p_last_drains_r7: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_ready && pix_last) |=> !pix_valid);
endmodule

// File: rtl/tri_raster.sv
module tri_raster
  import tri_raster_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tri_valid,
  output logic                 tri_ready,
  input  logic signed [15:0]   v0_x,
  input  logic signed [15:0]   v0_y,
  input  logic signed [15:0]   v1_x,
  input  logic signed [15:0]   v1_y,
  input  logic signed [15:0]   v2_x,
  input  logic signed [15:0]   v2_y,
  output logic                 pix_valid,
  input  logic                 pix_ready,
  output logic signed [12:0]   pix_x,
  output logic signed [12:0]   pix_y,
  output logic                 pix_last,
  output logic                 busy
);
  walk_state_t state;

  vtx_t in0, in1, in2, s_top, s_mid, s_bot;
  vtx_t vt, vm, vb, ea, eb;

  assign in0 = '{x: v0_x, y: v0_y};
  assign in1 = '{x: v1_x, y: v1_y};
  assign in2 = '{x: v2_x, y: v2_y};

  tri_vsort u_sort (.in0(in0), .in1(in1), .in2(in2),
                    .top(s_top), .mid(s_mid), .bot(s_bot));

  // edge selection for the divider: 0 long, 1 top-mid, 2 mid-bot
  logic [1:0]           eidx;
  logic                 issued;
  logic signed [CW:0]   edx, edy;
  logic [CW:0]          adx;
  logic [NW-1:0]        div_num, div_quo;
  logic                 div_start, div_busy, div_done;
  logic signed [SW-1:0] q_lo, q_signed;

  always_comb begin
    unique case (eidx)
      2'd0:    begin ea = vt; eb = vb; end
      2'd1:    begin ea = vt; eb = vm; end
      default: begin ea = vm; eb = vb; end
    endcase
  end

  assign edx       = {eb.x[CW-1], eb.x} - {ea.x[CW-1], ea.x};
  assign edy       = {eb.y[CW-1], eb.y} - {ea.y[CW-1], ea.y};
  assign adx       = edx[CW] ? CW'(0) - edx : edx;
  assign div_num   = {adx, {SF{1'b0}}};
  assign div_start = (state == ST_DIV) && (edy != '0) && !issued;
  assign q_lo      = div_quo[SW-1:0];
  assign q_signed  = edx[CW] ? -q_lo : q_lo;

  tri_slope_div #(.NW(NW), .DW(CW)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num),
    .den(edy[CW-1:0]), .busy(div_busy), .done(div_done), .quo(div_quo));

  // edge walking state
  logic signed [SW-1:0] slp_l, slp_tm, slp_mb;
  logic signed [SW-1:0] xl, xs, ss, xmb;
  logic signed [XW-1:0] row, row_mid, row_end, px, px_end;
  logic                 switched;
  logic signed [SW-1:0] lo_x, hi_x;

  assign lo_x = (xl < xs) ? xl : xs;
  assign hi_x = (xl < xs) ? xs : xl;

  logic gen_valid, gen_take, flush, out_empty;
  assign gen_valid = (state == ST_PIX) && (px < px_end);
  assign flush     = state == ST_DONE;
  assign busy      = state != ST_IDLE;
  assign tri_ready = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      vt       <= '0;
      vm       <= '0;
      vb       <= '0;
      eidx     <= '0;
      issued   <= 1'b0;
      slp_l    <= '0;
      slp_tm   <= '0;
      slp_mb   <= '0;
      xl       <= '0;
      xs       <= '0;
      ss       <= '0;
      xmb      <= '0;
      row      <= '0;
      row_mid  <= '0;
      row_end  <= '0;
      px       <= '0;
      px_end   <= '0;
      switched <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (tri_valid) begin
          vt     <= s_top;
          vm     <= s_mid;
          vb     <= s_bot;
          eidx   <= '0;
          issued <= 1'b0;
          state  <= ST_DIV;
        end
        ST_DIV: begin
          if (edy == '0 || (issued && div_done)) begin
            unique case (eidx)
              2'd0:    slp_l  <= (edy == '0) ? '0 : q_signed;
              2'd1:    slp_tm <= (edy == '0) ? '0 : q_signed;
              default: slp_mb <= (edy == '0) ? '0 : q_signed;
            endcase
            issued <= 1'b0;
            if (eidx == 2'd2) state <= ST_SETUP;
            else              eidx  <= eidx + 1'b1;
          end else if (!issued) begin
            issued <= 1'b1;
          end
        end
        ST_SETUP: begin
          xl       <= snap_x(vt.x, vt.y, slp_l);
          xs       <= snap_x(vt.x, vt.y, slp_tm);
          ss       <= slp_tm;
          xmb      <= snap_x(vm.x, vm.y, slp_mb);
          row      <= ceil_q4(vt.y);
          row_mid  <= ceil_q4(vm.y);
          row_end  <= ceil_q4(vb.y);
          switched <= 1'b0;
          state    <= ST_ROW;
        end
        ST_ROW: begin
          if (row >= row_end) begin
            state <= ST_DONE;
          end else if (row == row_mid && !switched) begin
            xs       <= xmb;
            ss       <= slp_mb;
            switched <= 1'b1;
          end else begin
            px     <= ceil_q16(lo_x);
            px_end <= ceil_q16(hi_x);
            state  <= ST_PIX;
          end
        end
        ST_PIX: begin
          if (gen_valid) begin
            if (gen_take) px <= px + XW'(1);
          end else begin
            row   <= row + XW'(1);
            xl    <= xl + slp_l;
            xs    <= xs + ss;
            state <= ST_ROW;
          end
        end
        ST_DONE: if (out_empty) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic [XW-1:0] o_x, o_y;

  tri_pix_out #(.XW(XW)) u_out (
    .clk(clk), .rst(rst), .gen_valid(gen_valid), .gen_x(px), .gen_y(row),
    .flush(flush), .gen_take(gen_take), .empty(out_empty),
    .pix_ready(pix_ready), .pix_valid(pix_valid), .pix_x(o_x), .pix_y(o_y),
    .pix_last(pix_last));

  assign pix_x = o_x;
  assign pix_y = o_y;

  // R1: registered vertices are in top-to-bottom order
  p_sorted_r1: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (vt.y <= vm.y && vm.y <= vb.y));

  // R8: an accepted triangle makes the block busy
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (tri_valid && tri_ready) |=> busy);

  // R8: pixels only appear while a triangle is in progress
  p_pix_needs_busy_r8: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> busy);

  // R5: span generation stays inside the row range
  p_row_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PIX) |-> (row < row_end));
endmodule

// File: tb/tri_raster_bench.sv
module tri_raster_bench;
  localparam int PERIOD = 10;
  localparam int MAXP   = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(PERIOD/2) clk = ~clk;

  logic tri_valid = 1'b0, pix_ready = 1'b1;
  logic tri_ready, pix_valid, pix_last, busy;
  logic signed [15:0] v0_x = '0, v0_y = '0, v1_x = '0, v1_y = '0, v2_x = '0, v2_y = '0;
  logic signed [12:0] pix_x, pix_y;

  tri_raster u_tri_raster (
    .clk(clk), .rst(rst), .tri_valid(tri_valid), .tri_ready(tri_ready),
    .v0_x(v0_x), .v0_y(v0_y), .v1_x(v1_x), .v1_y(v1_y), .v2_x(v2_x), .v2_y(v2_y),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_x(pix_x), .pix_y(pix_y),
    .pix_last(pix_last), .busy(busy));

  int total = 0, bad = 0;
  int ex [MAXP];
  int ey [MAXP];
  int n_exp;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [15:0] step_lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic longint ceil4(input longint y);
    return (y + 15) >>> 4;
  endfunction

  function automatic longint ceil16(input longint v);
    return (v + 65535) >>> 16;
  endfunction

  function automatic longint edge_slope(input longint dx, input longint dy);
    longint q;
    if (dy == 0) return 0;
    q = ((dx < 0 ? -dx : dx) * 65536) / dy;
    return (dx < 0) ? -q : q;
  endfunction

  function automatic longint start_x(input longint x, input longint y, input longint s);
    longint f;
    f = (16 - (y & 15)) & 15;
    return x * 4096 + ((s * f) >>> 4);
  endfunction

  // expected pixel list from the requirements
  function automatic void model(input int ax, input int ay, input int bx, input int by,
                                input int cx, input int cy);
    int vx [3];
    int vy [3];
    longint sl, stm, smb, xl, xs, ss, lo, hi, rmid;
    bit sw;
    vx[0] = ax; vy[0] = ay; vx[1] = bx; vy[1] = by; vx[2] = cx; vy[2] = cy;
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2 - i; j++)
        if (vy[j+1] < vy[j]) begin
          int tx, ty;
          tx = vx[j]; ty = vy[j];
          vx[j] = vx[j+1]; vy[j] = vy[j+1];
          vx[j+1] = tx; vy[j+1] = ty;
        end
    sl  = edge_slope(vx[2] - vx[0], vy[2] - vy[0]);
    stm = edge_slope(vx[1] - vx[0], vy[1] - vy[0]);
    smb = edge_slope(vx[2] - vx[1], vy[2] - vy[1]);
    xl = start_x(vx[0], vy[0], sl);
    xs = start_x(vx[0], vy[0], stm);
    ss = stm;
    sw = 1'b0;
    rmid = ceil4(vy[1]);
    n_exp = 0;
    for (longint r = ceil4(vy[0]); r < ceil4(vy[2]); r++) begin
      if (r == rmid && !sw) begin
        xs = start_x(vx[1], vy[1], smb);
        ss = smb;
        sw = 1'b1;
      end
      lo = (xl < xs) ? xl : xs;
      hi = (xl < xs) ? xs : xl;
      for (longint x = ceil16(lo); x < ceil16(hi); x++) begin
        if (n_exp < MAXP) begin
          ex[n_exp] = int'(x);
          ey[n_exp] = int'(r);
        end
        n_exp++;
      end
      xl += sl;
      xs += ss;
    end
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_tri(input int ax, input int ay, input int bx, input int by,
                         input int cx, input int cy, input string tag, input int mode);
    int got, cyc, last_cyc;
    bit stall_pend, saw_ready_hi;
    logic signed [12:0] sx, sy;
    logic sl_;
    model(ax, ay, bx, by, cx, cy);
    @(negedge clk);
    check(tri_ready == 1'b1 && busy == 1'b0, "R8", "tri_ready before accept", int'(tri_ready), 1);
    v0_x = 16'(ax); v0_y = 16'(ay); v1_x = 16'(bx); v1_y = 16'(by); v2_x = 16'(cx); v2_y = 16'(cy);
    tri_valid = 1'b1;
    @(negedge clk);
    tri_valid = 1'b0;
    check(busy == 1'b1 && tri_ready == 1'b0, "R8", "busy after accept", int'(busy), 1);
    got = 0; cyc = 0; last_cyc = -1; stall_pend = 1'b0; saw_ready_hi = 1'b0;
    sx = '0; sy = '0; sl_ = 1'b0;
    while (busy && cyc < 20000) begin
      if (tri_ready) saw_ready_hi = 1'b1;
      lfsr = step_lfsr(lfsr);
      case (mode)
        0: pix_ready = 1'b1;
        1: pix_ready = lfsr[0];
        default: pix_ready = lfsr[0] & lfsr[3] & lfsr[7];
      endcase
      if (stall_pend)
        check(pix_valid && pix_x == sx && pix_y == sy && pix_last == sl_, "R9",
              "stalled pixel changed", int'(pix_x), int'(sx));
      if (pix_valid && pix_ready) begin
        if (got < n_exp && got < MAXP) begin
          check(int'(pix_x) == ex[got], tag, "R5 R6 pixel x", int'(pix_x), ex[got]);
          check(int'(pix_y) == ey[got], tag, "R4 R6 pixel y", int'(pix_y), ey[got]);
          check(pix_last == (got == n_exp - 1), "R7", "last flag", int'(pix_last),
                int'(got == n_exp - 1));
        end else begin
          check(1'b0, "R7", "extra pixel index", got, n_exp);
        end
        if (pix_last) last_cyc = cyc;
        got++;
      end
      stall_pend = pix_valid && !pix_ready;
      sx = pix_x; sy = pix_y; sl_ = pix_last;
      @(negedge clk);
      cyc++;
    end
    pix_ready = 1'b1;
    check(!busy, "R8", "triangle finished", cyc, 20000);
    check(!saw_ready_hi, "R8", "tri_ready high while busy", int'(saw_ready_hi), 0);
    check(got == n_exp, tag, "R7 pixel count", got, n_exp);
    if (n_exp > 0)
      check(last_cyc >= 0 && cyc - last_cyc <= 2, "R8", "busy drop after last",
            cyc - last_cyc, 2);
  endtask

  initial begin
    #(PERIOD * 190000);
    bad++;
    total++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(pix_valid == 1'b0, "R10", "pix_valid after reset", int'(pix_valid), 0);
    check(busy == 1'b0, "R10", "busy after reset", int'(busy), 0);
    check(tri_ready == 1'b1, "R10", "tri_ready after reset", int'(tri_ready), 1);

    // corner cases
    run_tri(8, 5, 150, 40, 60, 170, "R3", 0);           // fractional starts
    run_tri(0, 0, 160, 0, 80, 128, "R4", 1);            // flat top
    run_tri(80, 0, 0, 128, 160, 128, "R4", 2);          // flat bottom
    run_tri(32, 32, 128, 32, 32, 128, "R5", 0);         // vertices on centres
    run_tri(16, 0, 24, 190, 40, 100, "R2", 1);          // steep edges
    run_tri(150, 3, 10, 170, 140, 180, "R2", 2);        // negative slopes
    run_tri(-40, -30, 50, -20, 0, 60, "R5", 1);         // negative coordinates
    run_tri(0, 0, 64, 64, 128, 128, "R7", 0);           // collinear, empty
    run_tri(0, 17, 90, 17, 40, 17, "R7", 1);            // zero height, empty
    run_tri(0, 1, 100, 5, 50, 14, "R7", 2);             // between centre rows

    // R1 vertex order independence
    run_tri(13, 7, 170, 90, 40, 150, "R1", 0);
    run_tri(170, 90, 40, 150, 13, 7, "R1", 1);
    run_tri(40, 150, 13, 7, 170, 90, "R1", 2);
    run_tri(170, 90, 13, 7, 40, 150, "R1", 1);
    run_tri(13, 7, 40, 150, 170, 90, "R1", 0);
    run_tri(40, 150, 170, 90, 13, 7, "R1", 2);

    // sweep of small triangles
    for (int k = 0; k < 240; k++) begin
      int c [6];
      for (int j = 0; j < 6; j++) begin
        lfsr = step_lfsr(lfsr);
        lfsr = step_lfsr(lfsr);
        c[j] = int'(lfsr[7:0]) - 32;
      end
      run_tri(c[0], c[1], c[2], c[3], c[4], c[5], "R5", k % 3);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule